// File: doc/BRIEF.md
# Multiplexed Three-Decade BCD Counter

The block counts falling edges of a slow count input in decimal, across three cascaded decades (units, tens, hundreds). The count input is sampled on the system clock, passed through a short synchronizer, and edge-detected. Only a high-to-low transition advances the count. A clock-disable input blocks counting and keeps the present value. A master clear zeroes the count. An overflow output gives a single-cycle pulse each time the count wraps from 999 to 000, so that a second unit can be cascaded from it.

The count passes through a hold latch before it reaches the display side. The latch follows the counter while its control is low and freezes while it is high, even across a master clear. A scan divider then presents one latched digit at a time on a 4-bit active-high BCD output, together with three active-low digit selects. The selects step units, tens, hundreds at a parameterized rate, set by default for a full refresh of about 60 Hz from a 50 MHz clock. While master clear is high the scanner is parked on the units digit with every select inactive.

Top module: `bcd_scan_counter`

## Requirements
- R1: A falling edge on `cnt_in` raises the count by one. The new value reaches the display within eight clock cycles. A rising edge leaves the count unchanged.
- R2: Each decade holds only the values 0 to 9. The units decade wrapping 9 to 0 advances the tens, the tens wrapping advances the hundreds, and 999 advances to 000.
- R3: While `clr` is high, all three decades are cleared, every bit of `dsel_n` is 1, and the scan does not advance. `clr` takes priority over a count edge in the same cycle.
- R4: While `hold_cnt` is high, falling edges on `cnt_in` are ignored and the count keeps its value.
- R5: While `freeze` is low, the displayed digits follow the count. While `freeze` is high, the displayed digits keep the value they had when `freeze` rose, regardless of counting and of `clr`.
- R6: Outside reset and clear, exactly one bit of `dsel_n` is 0. Bit 0 selects the units digit, bit 1 the tens and bit 2 the hundreds. They are visited in that order, each for SCAN_DIV cycles.
- R7: `bcd_out` carries the active-high BCD code of the digit whose select is low, in the same cycle as that select.
- R8: `ovf_pulse` is high for exactly one cycle per wrap from 999 to 000, which is once per 1000 counted edges.
- R9: While `rst` is high, `dsel_n` is 3'b111, `bcd_out` is 0 and `ovf_pulse` is 0. After reset the count and the latch read 000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high system reset |
| cnt_in | input | 1 | Count input, counted on its falling edge |
| clr | input | 1 | Master clear: zeroes the count, parks and blanks the scanner |
| hold_cnt | input | 1 | High blocks counting |
| freeze | input | 1 | High holds the display latch, low makes it transparent |
| bcd_out | output | 4 | BCD code of the selected digit, active high |
| dsel_n | output | 3 | Active-low digit selects: [0] units, [1] tens, [2] hundreds |
| ovf_pulse | output | 1 | One-cycle pulse on each wrap from 999 to 000 |

## Verification
The hardest situation to reach is the full rollover from 999 to 000 with its overflow pulse, because it takes a thousand counted edges while the count is visible only one scanned digit at a time. The stimulus drives edges back to back until the bench's own count model reaches 999, then drives one more edge. The bench counts overflow pulses on every cycle and checks all three decades reading zero. A second hard case is a clear issued while the latch is frozen. The bench scans the display during the freeze and again after the latch is released, to show that the count was zeroed underneath while the held value stayed on the display.

// File: rtl/bcd_scan_pkg.sv
package bcd_scan_pkg;
  localparam int DIG_W = 4;
  typedef logic [DIG_W-1:0] bcd_t;
  localparam bcd_t BCD_MAX = 4'd9;
endpackage

// File: rtl/bcd_edge_detect.sv
module bcd_edge_detect #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic sig_in,
  output logic fall
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], sig_in};
      prev_q <= sync_q[SYNC_STAGES-1];
    end
  end

  assign fall = prev_q & ~sync_q[SYNC_STAGES-1];

  // R1
  fall_single_chk: assert property (@(posedge clk) disable iff (rst)
    fall |=> !fall);
endmodule

// File: rtl/bcd_decade.sv
module bcd_decade
  import bcd_scan_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic inc,
  output bcd_t digit,
  output logic carry
);
  always_ff @(posedge clk) begin
    if (rst || clr)
      digit <= '0;
    else if (inc)
      digit <= (digit == BCD_MAX) ? '0 : digit + 1'b1;
  end

  assign carry = inc && (digit == BCD_MAX);

  // R2
  digit_range_chk: assert property (@(posedge clk) disable iff (rst)
    digit <= BCD_MAX);
endmodule

// File: rtl/bcd_digit_scan.sv
module bcd_digit_scan
  import bcd_scan_pkg::*;
#(
  parameter int NUM_DIGITS = 3,
  parameter int SCAN_DIV   = 277_778
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        clr,
  input  logic [NUM_DIGITS*DIG_W-1:0] digits_in,
  output bcd_t                        bcd_out,
  output logic [NUM_DIGITS-1:0]       dsel_n
);
  localparam int IW = (NUM_DIGITS > 1) ? $clog2(NUM_DIGITS) : 1;
  localparam int CW = (SCAN_DIV > 1) ? $clog2(SCAN_DIV) : 1;
  localparam logic [CW-1:0] DIV_LAST = CW'(SCAN_DIV - 1);
  localparam logic [IW-1:0] IDX_LAST = IW'(NUM_DIGITS - 1);

  logic [CW-1:0] div_q;
  logic [IW-1:0] idx_q;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      div_q   <= '0;
      idx_q   <= '0;
      dsel_n  <= '1;
      bcd_out <= '0;
    end else begin
      if (div_q == DIV_LAST) begin
        div_q <= '0;
        idx_q <= (idx_q == IDX_LAST) ? '0 : idx_q + 1'b1;
      end else begin
        div_q <= div_q + 1'b1;
      end
      dsel_n  <= ~(NUM_DIGITS'(1) << idx_q);
      bcd_out <= digits_in[idx_q*DIG_W +: DIG_W];
    end
  end

  // R6
  scan_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    (!clr && !$past(clr) && !$past(rst)) |-> ($countones(~dsel_n) == 1));
  // R3
  clr_blank_chk: assert property (@(posedge clk) disable iff (rst)
    clr |=> (dsel_n == '1));
  // R6
  idx_bound_chk: assert property (@(posedge clk) disable iff (rst)
    idx_q <= IDX_LAST);
endmodule

// File: rtl/bcd_scan_counter.sv
module bcd_scan_counter
  import bcd_scan_pkg::*;
#(
  parameter int NUM_DIGITS  = 3,
  parameter int SCAN_DIV    = 277_778,
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  cnt_in,
  input  logic                  clr,
  input  logic                  hold_cnt,
  input  logic                  freeze,
  output logic [DIG_W-1:0]      bcd_out,
  output logic [NUM_DIGITS-1:0] dsel_n,
  output logic                  ovf_pulse
);
  localparam int VW = NUM_DIGITS * DIG_W;

  logic                fall;
  logic                advance;
  logic [NUM_DIGITS:0] inc;
  logic [VW-1:0]       count_flat;
  logic [VW-1:0]       latch_q;

  bcd_edge_detect #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk(clk), .rst(rst), .sig_in(cnt_in), .fall(fall)
  );

  assign advance = fall && !hold_cnt && !clr;
  assign inc[0]  = advance;

  for (genvar g = 0; g < NUM_DIGITS; g++) begin : g_decade
    bcd_decade u_dec (
      .clk(clk), .rst(rst), .clr(clr), .inc(inc[g]),
      .digit(count_flat[g*DIG_W +: DIG_W]), .carry(inc[g+1])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      latch_q   <= '0;
      ovf_pulse <= 1'b0;
    end else begin
      if (!freeze) latch_q <= count_flat;
      ovf_pulse <= inc[NUM_DIGITS];
    end
  end

  bcd_digit_scan #(.NUM_DIGITS(NUM_DIGITS), .SCAN_DIV(SCAN_DIV)) u_scan (
    .clk(clk), .rst(rst), .clr(clr), .digits_in(latch_q),
    .bcd_out(bcd_out), .dsel_n(dsel_n)
  );

  // R1
  count_moves_chk: assert property (@(posedge clk) disable iff (rst)
    (fall && !hold_cnt && !clr) |=> !$stable(count_flat));
  // R4
  hold_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (hold_cnt && !clr) |=> $stable(count_flat));
  // R5
  latch_hold_chk: assert property (@(posedge clk) disable iff (rst)
    freeze |=> $stable(latch_q));
  // R8
  ovf_single_chk: assert property (@(posedge clk) disable iff (rst)
    ovf_pulse |=> !ovf_pulse);
  // R3
  clr_zero_chk: assert property (@(posedge clk) disable iff (rst)
    clr |=> (count_flat == '0));
endmodule

// File: tb/bcd_scan_counter_bench.sv
module bcd_scan_counter_bench;
  localparam int DIV = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cnt_in = 1'b0, clr = 1'b0, hold_cnt = 1'b0, freeze = 1'b0;
  logic [3:0] bcd_out;
  logic [2:0] dsel_n;
  logic       ovf_pulse;

  int checks = 0, failures = 0;
  int exp_cnt = 0, exp_disp = 0, exp_ovf = 0, seen_ovf = 0;
  bit done = 0;

  always #10 clk = ~clk;

  bcd_scan_counter #(.NUM_DIGITS(3), .SCAN_DIV(DIV), .SYNC_STAGES(2)) u_bcd_scan_counter (
    .clk(clk), .rst(rst), .cnt_in(cnt_in), .clr(clr), .hold_cnt(hold_cnt),
    .freeze(freeze), .bcd_out(bcd_out), .dsel_n(dsel_n), .ovf_pulse(ovf_pulse)
  );

  always @(negedge clk) if (!rst && ovf_pulse) seen_ovf++;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int next_val(input int v);
    return (v + 1) % 1000;
  endfunction

  task automatic sync_disp();
    if (!freeze) exp_disp = exp_cnt;
  endtask

  task automatic pulse();
    @(negedge clk) cnt_in = 1'b1;
    repeat (3) @(negedge clk);
    cnt_in = 1'b0;
    repeat (4) @(negedge clk);
    if (!hold_cnt && !clr) begin
      if (exp_cnt == 999) exp_ovf++;
      exp_cnt = next_val(exp_cnt);
    end
    sync_disp();
  endtask

  task automatic read_disp(output int val, output bit onehot_ok);
    int d0 = 0, d1 = 0, d2 = 0;
    onehot_ok = 1;
    repeat (3*DIV + 2) begin
      @(negedge clk);
      case (dsel_n)
        3'b110: d0 = bcd_out;
        3'b101: d1 = bcd_out;
        3'b011: d2 = bcd_out;
        default: onehot_ok = 0;
      endcase
    end
    val = d2*100 + d1*10 + d0;
  endtask

  task automatic check_disp(input string req);
    int v; bit oh;
    read_disp(v, oh);
    chk(v == exp_disp, req, v, exp_disp);
    chk(oh, "R6 one select low", oh, 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int v; bit oh;
    void'($urandom(32'd5150));
    repeat (3) @(negedge clk);
    // R9 reset state
    chk(dsel_n == 3'b111, "R9 dsel in reset", dsel_n, 7);
    chk(bcd_out == 0 && ovf_pulse == 0, "R9 outputs in reset", bcd_out, 0);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    check_disp("R9 zero after reset");

    // R6 scan order and dwell
    while (dsel_n != 3'b110) @(negedge clk);
    while (dsel_n == 3'b110) @(negedge clk);
    while (dsel_n != 3'b110) @(negedge clk);
    begin
      int n = 0;
      while (dsel_n == 3'b110) begin n++; @(negedge clk); end
      chk(n == DIV, "R6 units dwell", n, DIV);
      chk(dsel_n == 3'b101, "R6 tens after units", dsel_n, 5);
      repeat (DIV) @(negedge clk);
      chk(dsel_n == 3'b011, "R6 hundreds after tens", dsel_n, 3);
    end

    // R1 single edges, R7 digit values
    repeat (5) pulse();
    check_disp("R1 five edges");
    @(negedge clk) cnt_in = 1'b1;
    repeat (6) @(negedge clk);
    check_disp("R1 rising edge no count");
    cnt_in = 1'b0; repeat (4) @(negedge clk);
    exp_cnt = next_val(exp_cnt); sync_disp();
    check_disp("R7 digit codes");

    // R2 cascades
    while (exp_cnt != 9) pulse();
    check_disp("R2 units at nine");
    pulse();
    check_disp("R2 units carry to tens");
    while (exp_cnt != 100) pulse();
    check_disp("R2 tens carry to hundreds");

    // R4 hold
    hold_cnt = 1'b1;
    repeat (3) pulse();
    check_disp("R4 hold blocks edges");
    hold_cnt = 1'b0;

    // R5 freeze then count and clear underneath
    @(negedge clk) freeze = 1'b1;
    repeat (4) pulse();
    check_disp("R5 frozen while counting");
    @(negedge clk) clr = 1'b1; exp_cnt = 0;
    repeat (2) @(negedge clk);
    chk(dsel_n == 3'b111, "R3 selects off in clear", dsel_n, 7);
    pulse();
    chk(dsel_n == 3'b111, "R3 scan stopped in clear", dsel_n, 7);
    @(negedge clk) clr = 1'b0;
    begin
      int n = 0;
      @(negedge clk);
      while (dsel_n == 3'b110) begin n++; @(negedge clk); end
      chk(n == DIV, "R3 restart on units", n, DIV);
    end
    check_disp("R5 frozen across clear");
    @(negedge clk) freeze = 1'b0;
    repeat (2) @(negedge clk); sync_disp();
    check_disp("R3 count cleared");

    // R8 rollover
    seen_ovf = 0; exp_ovf = 0;
    while (exp_cnt != 999) pulse();
    check_disp("R2 at 999");
    chk(seen_ovf == 0, "R8 no pulse before wrap", seen_ovf, 0);
    pulse();
    check_disp("R2 wrap to 000");
    chk(seen_ovf == 1, "R8 one pulse per wrap", seen_ovf, 1);

    // random mix
    for (int i = 0; i < 250; i++) begin
      case ($urandom % 5)
        0, 1: pulse();
        2: begin hold_cnt = ($urandom % 2) == 1; pulse(); hold_cnt = 1'b0; end
        3: begin @(negedge clk) freeze = ~freeze; repeat (2) @(negedge clk); sync_disp(); end
        default: check_disp("R5 random display");
      endcase
    end
    @(negedge clk) freeze = 1'b0;
    repeat (2) @(negedge clk); sync_disp();
    check_disp("R1 random final count");
    chk(seen_ovf == exp_ovf, "R8 random overflow count", seen_ovf, exp_ovf);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule